// File: doc/BRIEF.md
# Frame-Synchronized Shadow Route Memory

This block stores the time-slot routing tables of a single TDM channel. It keeps one table for the receive direction and one for the transmit direction. Each table has two physical areas. One area is active and feeds the serial side. The other is a shadow that the host can rewrite freely. A host port reads and writes any table word by byte address. A two-bit command register lets software ask for an exchange of the active and shadow areas of either direction.

Each direction has its own frame-sync pulse and its own time-slot strobe. A frame sync restarts that direction's entry pointer. If a swap is pending for that direction, the same sync also exchanges its areas and clears the request bit in hardware, which tells software the swap is complete. Each strobe moves the pointer on by one entry. The read-out port of each direction always presents the active entry at the pointer, so routing never stops while the shadow area is reprogrammed.

Each direction has two small state machines:
- The swap controller has the states SW_IDLE and SW_ARMED. It moves from SW_IDLE to SW_ARMED when the host writes 1 to the request bit. It moves from SW_ARMED back to SW_IDLE in two cases: when the host writes 0 (cancel), or when the direction's frame sync arrives with no command write in that cycle (swap).
- The slot pointer has the states PTR_RUN and PTR_HELD. It moves from PTR_RUN to PTR_HELD when a strobe advances the pointer onto the last entry. It moves from PTR_HELD back to PTR_RUN on a frame sync.

Top module: `route_shadow_mem`

## Requirements
- R1: Each table area holds 32 words of 32 bits. The host byte address decodes as follows: bit 8 selects the direction (0 = receive, 1 = transmit), bit 7 selects the physical area (0 = low, 1 = high), and bits 6:2 give the entry index. Bits 1:0 are ignored. A host write is stored at the clock edge. A host read request (`host_rd`) places the word on `host_rdata` after the next clock edge.
- R2: After reset, both directions use their low area as active, both request bits are 0, both entry pointers are 0, and `host_rdata` is 0. The active receive route is therefore at bytes 0–127 and the active transmit route at bytes 256–383.
- R3: `rx_entry` and `tx_entry` continuously show the word of their direction's active area at that direction's entry pointer.
- R4: A frame sync sets its direction's pointer to 0 at the clock edge. A strobe without a sync advances the pointer by one. The pointer holds at 31 until the next sync.
- R5: A `cmd_we` write stores `cmd_wdata[0]` as the receive request and `cmd_wdata[1]` as the transmit request. `cmd_stat` shows both pending bits in the same bit positions. Writing 0 to a pending bit cancels it, and no swap takes place.
- R6: A pending request of a direction takes effect at that direction's next frame sync. After that clock edge the active area has changed and the request bit reads 0.
- R7: A frame sync of one direction changes neither the request bit nor the active area of the other direction. Both directions can swap at the same edge.
- R8: When a command write and a frame sync of a direction occur in the same cycle, the sync acts on the request value held before the write. The written value is kept for the following sync.
- R9: Repeated swaps alternate between the two areas. Host writes to the current shadow area do not change that direction's read-out.
- R10: A frame sync with no pending request restarts the pointer only. The active area stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 9 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read request |
| host_rdata | output | 32 | Registered host read data |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 2 | Swap requests: bit 0 receive, bit 1 transmit |
| cmd_stat | output | 2 | Pending swap requests, same bit positions |
| rx_fsync | input | 1 | Receive frame-sync pulse |
| rx_strobe | input | 1 | Receive time-slot strobe |
| rx_entry | output | 32 | Active receive entry at the receive pointer |
| tx_fsync | input | 1 | Transmit frame-sync pulse |
| tx_strobe | input | 1 | Transmit time-slot strobe |
| tx_entry | output | 32 | Active transmit entry at the transmit pointer |

## Verification
Every word in all four areas is filled with a distinct value. Because of this, each read-out value shows both which area is active and where the pointer is.

The swap function is driven with several patterns:
- A receive-only request that meets a transmit sync first, which tells apart independent directions from shared ones.
- A request that is cancelled before its sync, which tells apart a real cancel from a swap that only got delayed.
- A request written in the same cycle as a sync, which tells apart acting on the old value from acting on the new one.
- Simultaneous requests on both directions with simultaneous syncs.

Strobe runs that are short, and runs longer than the table, separate a pointer that advances, wraps, or holds at the last entry. Rewrites of the shadow area followed by back-to-back swaps show that the read-out keeps coming from the active area and alternates on each swap.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    localparam int DIRS = 2;

    typedef enum logic {
        SW_IDLE,
        SW_ARMED
    } swap_state_e;

    typedef enum logic {
        PTR_RUN,
        PTR_HELD
    } ptr_state_e;

endpackage

// File: rtl/rsm_swap_ctrl.sv
module rsm_swap_ctrl
    import rsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic cmd_we,
    input  logic cmd_bit,
    output logic req_pending,
    output logic area_sel
);

    swap_state_e state_q, state_d;
    logic        area_q, area_d;
    logic        do_swap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            area_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            area_q  <= area_d;
        end
    end

    always_comb begin
        state_d = state_q;
        do_swap = 1'b0;
        unique case (state_q)
            SW_IDLE: begin
                if (cmd_we && cmd_bit)
                    state_d = SW_ARMED;
            end
            SW_ARMED: begin
                if (fsync)
                    do_swap = 1'b1;
                if (cmd_we)
                    state_d = cmd_bit ? SW_ARMED : SW_IDLE;
                else if (fsync)
                    state_d = SW_IDLE;
            end
        endcase
        area_d = area_q ^ do_swap;
    end

    always_comb begin
        req_pending = (state_q == SW_ARMED);
        area_sel    = area_q;
    end

    // R6
    swap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pending && fsync && !cmd_we) |=> (!req_pending && area_sel != $past(area_sel)));

    // R10
    no_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_pending) |=> $stable(area_sel));

    // R5
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_bit) |=> !req_pending);

    // R8
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_bit) |=> req_pending);

endmodule

// File: rtl/rsm_slot_ptr.sv
module rsm_slot_ptr
    import rsm_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             strobe,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST    = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LAST_M1 = IDX_W'(ENTRIES - 2);

    ptr_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_RUN;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            PTR_RUN: begin
                if (fsync) begin
                    ptr_d = '0;
                end else if (strobe) begin
                    if (ptr_q == LAST_M1) begin
                        ptr_d   = LAST;
                        state_d = PTR_HELD;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end
            end
            PTR_HELD: begin
                if (fsync) begin
                    ptr_d   = '0;
                    state_d = PTR_RUN;
                end
            end
        endcase
    end

    always_comb begin
        ptr = ptr_q;
    end

    // R4
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (ptr == '0));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !fsync && ptr != LAST) |=> (ptr == $past(ptr) + IDX_W'(1)));

    // R4
    hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == LAST && !fsync) |=> (ptr == LAST));

endmodule

// File: rtl/rsm_route_ram.sv
module rsm_route_ram #(
    parameter int DIRS    = 2,
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 32,
    localparam int WORDS  = DIRS * 2 * ENTRIES,
    localparam int WA_W   = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic                        host_rd,
    input  logic [WA_W-1:0]             host_widx,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic [DATA_W-1:0]           host_rdata,
    input  logic [DIRS-1:0][WA_W-1:0]   port_idx,
    output logic [DIRS-1:0][DATA_W-1:0] port_data
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (host_we)
            mem[host_widx] <= host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (host_rd)
            host_rdata <= mem[host_widx];
    end

    for (genvar p = 0; p < DIRS; p++) begin : g_port
        assign port_data[p] = mem[port_idx[p]];
    end

endmodule

// File: rtl/route_shadow_mem.sv
module route_shadow_mem
    import rsm_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int DATA_W = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WA_W   = IDX_W + 2,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int ADDR_W = WA_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cmd_we,
    input  logic [DIRS-1:0]   cmd_wdata,
    output logic [DIRS-1:0]   cmd_stat,
    input  logic              rx_fsync,
    input  logic              rx_strobe,
    output logic [DATA_W-1:0] rx_entry,
    input  logic              tx_fsync,
    input  logic              tx_strobe,
    output logic [DATA_W-1:0] tx_entry
);

    logic [DIRS-1:0]              fsync_v, strobe_v, area_v, req_v;
    logic [DIRS-1:0][IDX_W-1:0]   ptr_v;
    logic [DIRS-1:0][WA_W-1:0]    idx_v;
    logic [DIRS-1:0][DATA_W-1:0]  data_v;
    logic                         unused_byte_bits;

    assign fsync_v          = {tx_fsync, rx_fsync};
    assign strobe_v         = {tx_strobe, rx_strobe};
    assign unused_byte_bits = ^host_addr[BYTE_W-1:0];

    for (genvar d = 0; d < DIRS; d++) begin : g_dir
        rsm_swap_ctrl u_swap (
            .clk         (clk),
            .rst_n       (rst_n),
            .fsync       (fsync_v[d]),
            .cmd_we      (cmd_we),
            .cmd_bit     (cmd_wdata[d]),
            .req_pending (req_v[d]),
            .area_sel    (area_v[d])
        );

        rsm_slot_ptr #(.ENTRIES(ENTRIES)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .fsync  (fsync_v[d]),
            .strobe (strobe_v[d]),
            .ptr    (ptr_v[d])
        );

        assign idx_v[d] = {1'(d), area_v[d], ptr_v[d]};
    end

    rsm_route_ram #(
        .DIRS    (DIRS),
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W)
    ) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_rd    (host_rd),
        .host_widx  (host_addr[ADDR_W-1:BYTE_W]),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .port_idx   (idx_v),
        .port_data  (data_v)
    );

    assign cmd_stat = req_v;
    assign rx_entry = data_v[0];
    assign tx_entry = data_v[1];

    // R7
    rx_sync_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fsync && !tx_fsync && !cmd_we) |=> ($stable(cmd_stat[1]) && $stable(area_v[1])));

    // R7
    tx_sync_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fsync && !rx_fsync && !cmd_we) |=> ($stable(cmd_stat[0]) && $stable(area_v[0])));

    // R9
    shadow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !rx_fsync && !rx_strobe && host_addr[ADDR_W-1] == 1'b0
         && host_addr[ADDR_W-2] != area_v[0]) |=> $stable(rx_entry));

endmodule

// File: tb/route_shadow_mem_test.sv
module route_shadow_mem_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_wdata = '0;
    logic [1:0]  cmd_stat;
    logic        rx_fsync = 1'b0, rx_strobe = 1'b0, tx_fsync = 1'b0, tx_strobe = 1'b0;
    logic [31:0] rx_entry, tx_entry;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] mm [128];
    int m_sel [2];
    int m_req [2];
    int m_ptr [2];

    always #10 clk = ~clk;

    route_shadow_mem uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_stat(cmd_stat),
        .rx_fsync(rx_fsync), .rx_strobe(rx_strobe), .rx_entry(rx_entry),
        .tx_fsync(tx_fsync), .tx_strobe(tx_strobe), .tx_entry(tx_entry)
    );

    function automatic logic [31:0] pat(int w, int salt);
        return 32'(w) * 32'h9E37_79B1 + 32'(salt) * 32'h0101_0707 + 32'h0000_1234;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(string tag);
        chk({tag, " rx_entry"}, rx_entry, mm[m_sel[0]*32 + m_ptr[0]]);
        chk({tag, " tx_entry"}, tx_entry, mm[64 + m_sel[1]*32 + m_ptr[1]]);
        chk({tag, " cmd_stat"}, {30'd0, cmd_stat}, 32'(m_req[1]*2 + m_req[0]));
    endtask

    // One cycle of serial/command stimulus, with the expected-state model
    task automatic cyc(logic we, logic [1:0] bits, logic [1:0] sync, logic [1:0] stb);
        cmd_we = we; cmd_wdata = bits;
        rx_fsync = sync[0]; tx_fsync = sync[1];
        rx_strobe = stb[0]; tx_strobe = stb[1];
        @(posedge clk); #1;
        cmd_we = 1'b0; rx_fsync = 1'b0; tx_fsync = 1'b0;
        rx_strobe = 1'b0; tx_strobe = 1'b0;
        for (int d = 0; d < 2; d++) begin
            if (sync[d]) begin
                m_ptr[d] = 0;
                if (m_req[d] != 0) begin
                    m_sel[d] = 1 - m_sel[d];
                    m_req[d] = 0;
                end
            end else if (stb[d] && m_ptr[d] < 31) begin
                m_ptr[d]++;
            end
            if (we) m_req[d] = int'(bits[d]);
        end
    endtask

    task automatic host_write(logic [8:0] a, logic [31:0] v);
        host_addr = a; host_wdata = v; host_we = 1'b1;
        @(posedge clk); #1;
        host_we = 1'b0;
        mm[a[8:2]] = v;
    endtask

    task automatic host_read_chk(logic [8:0] a, string tag);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
        chk(tag, host_rdata, mm[a[8:2]]);
    endtask

    task automatic t_reset;
        chk("R2 cmd_stat after reset", {30'd0, cmd_stat}, 32'd0);
        chk("R2 host_rdata after reset", host_rdata, 32'd0);
    endtask

    task automatic t_fill;
        for (int w = 0; w < 128; w++)
            host_write(9'(w*4 + (w % 4)), pat(w, 0));
        host_read_chk(9'd3, "R1 read rx low word0 low bits set");
        host_read_chk(9'(33*4 + 3), "R1 read rx high word1");
        host_read_chk(9'(70*4 + 1), "R1 read tx low word6");
        host_read_chk(9'(127*4 + 2), "R1 read tx high word31");
        chk_outputs("R2 low areas active after reset");
    endtask

    task automatic t_pointer;
        cyc(1'b0, 2'b00, 2'b11, 2'b00);
        chk_outputs("R4 sync restarts pointers");
        for (int i = 0; i < 5; i++) cyc(1'b0, 2'b00, 2'b00, 2'b11);
        chk_outputs("R3 entry at slot 5");
        cyc(1'b0, 2'b00, 2'b00, 2'b01);
        chk_outputs("R3 rx advances alone");
        for (int i = 0; i < 40; i++) cyc(1'b0, 2'b00, 2'b00, 2'b11);
        chk_outputs("R4 pointer holds at 31");
        cyc(1'b0, 2'b00, 2'b11, 2'b11);
        chk_outputs("R4 sync wins over strobe");
    endtask

    task automatic t_swap_rx;
        cyc(1'b1, 2'b01, 2'b00, 2'b00);
        chk_outputs("R5 rx request stored, area kept");
        cyc(1'b0, 2'b00, 2'b10, 2'b00);
        chk_outputs("R7 tx sync leaves rx request");
        cyc(1'b0, 2'b00, 2'b01, 2'b00);
        chk_outputs("R6 rx swap at rx sync");
        chk("R6 rx high word0 active", rx_entry, pat(32, 0));
    endtask

    task automatic t_cancel;
        cyc(1'b1, 2'b01, 2'b00, 2'b00);
        cyc(1'b1, 2'b00, 2'b00, 2'b00);
        chk_outputs("R5 cancel clears request");
        cyc(1'b0, 2'b00, 2'b01, 2'b00);
        chk_outputs("R5 no swap after cancel");
    endtask

    task automatic t_same_cycle;
        cyc(1'b1, 2'b01, 2'b01, 2'b00);
        chk_outputs("R8 write with sync defers");
        cyc(1'b0, 2'b00, 2'b00, 2'b01);
        cyc(1'b0, 2'b00, 2'b01, 2'b00);
        chk_outputs("R8 swap at following sync");
        cyc(1'b1, 2'b01, 2'b00, 2'b00);
        cyc(1'b1, 2'b01, 2'b01, 2'b00);
        chk_outputs("R8 swap on old request, new request kept");
        cyc(1'b1, 2'b00, 2'b00, 2'b00);
    endtask

    task automatic t_shadow;
        for (int k = 0; k < 3; k++) begin
            host_write(9'((1 - m_sel[0]) * 128), pat(k, 9));
            chk_outputs("R9 shadow write invisible");
            cyc(1'b1, 2'b01, 2'b00, 2'b00);
            cyc(1'b0, 2'b00, 2'b01, 2'b00);
            chk_outputs("R9 swap alternates");
            chk("R9 new word visible", rx_entry, pat(k, 9));
        end
    endtask

    task automatic t_nosync;
        cyc(1'b0, 2'b00, 2'b00, 2'b11);
        cyc(1'b0, 2'b00, 2'b00, 2'b11);
        cyc(1'b0, 2'b00, 2'b11, 2'b00);
        chk_outputs("R10 sync without request keeps area");
    endtask

    task automatic t_both;
        cyc(1'b1, 2'b10, 2'b00, 2'b00);
        cyc(1'b0, 2'b00, 2'b01, 2'b00);
        chk_outputs("R7 rx sync leaves tx request");
        cyc(1'b0, 2'b00, 2'b10, 2'b00);
        chk_outputs("R6 tx swap at tx sync");
        chk("R6 tx high word0 active", tx_entry, pat(96, 0));
        cyc(1'b1, 2'b11, 2'b00, 2'b00);
        cyc(1'b0, 2'b00, 2'b11, 2'b00);
        chk_outputs("R7 both swap at same edge");
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_sel[d] = 0; m_req[d] = 0; m_ptr[d] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset;
        t_fill;
        t_pointer;
        t_swap_rx;
        t_cancel;
        t_same_cycle;
        t_shadow;
        t_nosync;
        t_both;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule